// File: doc/BRIEF.md
# Codec Status Slot Generator

This block builds the two fixed-format 20-bit status words that an audio codec returns to its controller on every frame of its serial link: the register read-back word (slot 2) and the pin and interrupt status word (slot 12). It also provides the register address that accompanies the read-back word in slot 1. A one-cycle frame strobe marks each frame boundary. On that strobe, all three outputs are loaded together. They then hold steady while an external shifter sends them out.

A register read that arrives during one frame is held as pending. It is presented only after the next strobe, so its address and data always come back one frame late. The five general-purpose pins report different things depending on direction. An input pin reports its live level. An output pin reports the level the controller commanded, but one frame after the command. Three sticky status banks feed the interrupt flags: pin wake events, BIOS events and internal errors. Each status bit is set by a rising edge on its source and stays set until the host writes a zero to it.

Top module: `codec_status_slots`

## Requirements
- R1: After reset, slot1_addr_o, slot1_valid_o, slot2_o and slot12_o are all zero. All status bits, the pending read and the output-pin echo register are also zero.
- R2: A read response presented on rd_valid_i in the cycles after a frame strobe, up to and including the cycle before the next strobe, is loaded at that next strobe. From then on slot1_valid_o is 1 and slot1_addr_o carries its address. If a later request arrives in the same frame, the later one replaces the earlier one. A response presented in the same cycle as a strobe belongs to the following frame. A strobe with nothing pending drives slot1_valid_o, slot1_addr_o and slot2_o to zero.
- R3: The slot 2 word has the read data in bits 19..4 and zero in bits 3..0.
- R4: The slot 12 word has zero in bits 19..9 and bit 3. Bits 8..4 carry pins 4..0. Bit 2 is the BIOS-event flag, bit 1 is the error flag and bit 0 is the merged interrupt flag.
- R5: For a pin with gpio_dir_i bit 0 (input), slot 12 reports the pin level sampled at the frame strobe.
- R6: For a pin with gpio_dir_i bit 1 (output), slot 12 reports the gpio_ctl_i level that was captured at the previous strobe, not the level present at the current strobe.
- R7: A BIOS-event status bit sets on a rising edge of its source, whatever the configuration mask says. The BIOS-event flag equals the OR of the status bits ANDed with bdi_cfg_i.
- R8: An error status bit sets on a rising edge of its source only while its iec_en_i bit is 1. The error flag is the OR of all error status bits, with no mask.
- R9: A pin status bit sets on a rising edge of the pin only when the pin is an input and its gpio_wake_i bit is 1.
- R10: The interrupt flag is 1 when any pin status bit is set, when the BIOS-event flag condition holds, or when any error status bit is set.
- R11: When clr_sel_i is 0 (pins), 1 (BIOS events) or 2 (errors), each bit of that bank whose clr_data_i bit is 0 is cleared. Bits written as 1 are unchanged. A clr_sel_i value of 3 clears nothing.
- R12: If a set condition and a clear hit the same status bit in the same cycle, the bit ends up set.
- R13: slot1_addr_o, slot1_valid_o, slot2_o and slot12_o change only on the clock edge where frame_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | One-cycle frame-boundary strobe |
| rd_valid_i | input | 1 | Register read response available |
| rd_addr_i | input | ADDR_W | Address of the read response |
| rd_data_i | input | 16 | Data of the read response |
| gpio_pin_i | input | 5 | Pin levels |
| gpio_dir_i | input | 5 | Pin direction, 1 = output |
| gpio_ctl_i | input | 5 | Output levels commanded in the incoming slot 12 |
| gpio_wake_i | input | 5 | Per-pin interrupt enable |
| bdi_evt_i | input | BDI_W | BIOS-event sources |
| bdi_cfg_i | input | BDI_W | BIOS-event flag mask |
| iec_evt_i | input | IEC_W | Internal error sources |
| iec_en_i | input | IEC_W | Internal error capture enables |
| clr_sel_i | input | 2 | Bank to clear: 0 pins, 1 BIOS events, 2 errors, 3 none |
| clr_data_i | input | CLR_W | Clear word; a 0 bit clears the status bit |
| slot1_addr_o | output | ADDR_W | Read address for slot 1 |
| slot1_valid_o | output | 1 | Slot 1 and slot 2 carry a read response |
| slot2_o | output | 20 | Slot 2 word |
| slot12_o | output | 20 | Slot 12 word |

## Verification
The hardest case to reach from the ports is a set and a clear landing on the same status bit in the same cycle. The set must come from a genuine rising edge, and it has to arrive exactly while the host is writing zero to that same bit of that same bank. Random stimulus almost never lines these up, so a directed step raises an enabled error source in the same cycle as a clearing write. The bench then confirms at the next strobe that the flag survived.

The one-frame lag of output pins is a second case. It only shows up when the commanded level changes between two strobes, so a directed sequence compares the first and second frames after such a change. A long random phase then mixes changes in direction, wake enable, mask and enable with read responses and clears, and checks every output field in every cycle against a bench model.

// File: rtl/codec_status_pkg.sv
package codec_status_pkg;
  localparam int SLOT_W  = 20;
  localparam int GPIO_W  = 5;
  localparam int RDATA_W = 16;
  localparam int SLOT2_PAD_W = SLOT_W - RDATA_W;

  typedef enum logic [1:0] {
    CLR_GPIO = 2'd0,
    CLR_BDI  = 2'd1,
    CLR_IEC  = 2'd2,
    CLR_NONE = 2'd3
  } clr_sel_e;

  typedef struct packed {
    logic [10:0]       zero_hi;
    logic [GPIO_W-1:0] pins;
    logic              rsvd;
    logic              bdi;
    logic              iec;
    logic              irq;
  } slot12_t;
endpackage

// File: rtl/sts_sticky_bank.sv
module sts_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] evt_q, sts_q, set_vec, clr_vec;

  assign set_vec = evt_i & ~evt_q & en_i;
  assign clr_vec = clr_i ? ~clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      sts_q <= '0;
    end else begin
      evt_q <= evt_i;
      sts_q <= (sts_q & ~clr_vec) | set_vec;  // set beats clear
    end
  end

  assign sts_o = sts_q;

  p_set_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((sts_q & $past(~clr_data_i & ~set_vec)) == '0));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_vec == '0) |=> $stable(sts_q));
endmodule

// File: rtl/sts_read_return.sv
module sts_read_return
  import codec_status_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic                rd_valid_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [RDATA_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                valid_o,
  output logic [SLOT_W-1:0]   slot2_o
);
  logic                pend_v_q;
  logic [ADDR_W-1:0]   pend_addr_q;
  logic [RDATA_W-1:0]  pend_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q    <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      addr_o      <= '0;
      valid_o     <= 1'b0;
      slot2_o     <= '0;
    end else begin
      if (frame_i) begin
        valid_o  <= pend_v_q;
        addr_o   <= pend_v_q ? pend_addr_q : '0;
        slot2_o  <= pend_v_q ? {pend_data_q, {SLOT2_PAD_W{1'b0}}} : '0;
        pend_v_q <= rd_valid_i;
      end else if (rd_valid_i) begin
        pend_v_q <= 1'b1;
      end
      if (rd_valid_i) begin
        pend_addr_q <= rd_addr_i;
        pend_data_q <= rd_data_i;
      end
    end
  end

  p_no_stale_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !pend_v_q) |=> (!valid_o && slot2_o == '0));

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(slot2_o) && $stable(valid_o) && $stable(addr_o)));

  p_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (slot2_o[SLOT2_PAD_W-1:0] == '0));
endmodule

// File: rtl/sts_gpio_echo.sv
module sts_gpio_echo
  import codec_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic [GPIO_W-1:0] pin_i,
  input  logic [GPIO_W-1:0] dir_i,
  input  logic [GPIO_W-1:0] ctl_i,
  output logic [GPIO_W-1:0] lvl_o
);
  logic [GPIO_W-1:0] echo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      echo_q <= '0;
    else if (frame_i) echo_q <= ctl_i;
  end

  // output pins report last frame's command, inputs report the pin
  assign lvl_o = (dir_i & echo_q) | (~dir_i & pin_i);

  p_echo_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(echo_q));
endmodule

// File: rtl/codec_status_slots.sv
module codec_status_slots
  import codec_status_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BDI_W  = 8,
  parameter int IEC_W  = 4,
  localparam int MAX_BI = (BDI_W > IEC_W) ? BDI_W : IEC_W,
  localparam int CLR_W  = (MAX_BI > GPIO_W) ? MAX_BI : GPIO_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_i,
  input  logic                rd_valid_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic [RDATA_W-1:0]  rd_data_i,
  input  logic [GPIO_W-1:0]   gpio_pin_i,
  input  logic [GPIO_W-1:0]   gpio_dir_i,
  input  logic [GPIO_W-1:0]   gpio_ctl_i,
  input  logic [GPIO_W-1:0]   gpio_wake_i,
  input  logic [BDI_W-1:0]    bdi_evt_i,
  input  logic [BDI_W-1:0]    bdi_cfg_i,
  input  logic [IEC_W-1:0]    iec_evt_i,
  input  logic [IEC_W-1:0]    iec_en_i,
  input  logic [1:0]          clr_sel_i,
  input  logic [CLR_W-1:0]    clr_data_i,
  output logic [ADDR_W-1:0]   slot1_addr_o,
  output logic                slot1_valid_o,
  output logic [SLOT_W-1:0]   slot2_o,
  output logic [SLOT_W-1:0]   slot12_o
);
  logic [GPIO_W-1:0] gpio_sts, gpio_lvl;
  logic [BDI_W-1:0]  bdi_sts;
  logic [IEC_W-1:0]  iec_sts;
  logic              bdi_flag, iec_flag, irq_flag;
  slot12_t           slot12_d, slot12_q;

  sts_read_return #(.ADDR_W(ADDR_W)) u_read (
    .clk_i, .rst_ni, .frame_i,
    .rd_valid_i, .rd_addr_i, .rd_data_i,
    .addr_o (slot1_addr_o),
    .valid_o(slot1_valid_o),
    .slot2_o(slot2_o)
  );

  sts_gpio_echo u_echo (
    .clk_i, .rst_ni, .frame_i,
    .pin_i(gpio_pin_i), .dir_i(gpio_dir_i), .ctl_i(gpio_ctl_i),
    .lvl_o(gpio_lvl)
  );

  sts_sticky_bank #(.W(GPIO_W)) u_gpio_sts (
    .clk_i, .rst_ni,
    .evt_i(gpio_pin_i), .en_i(gpio_wake_i & ~gpio_dir_i),
    .clr_i(clr_sel_i == CLR_GPIO), .clr_data_i(clr_data_i[GPIO_W-1:0]),
    .sts_o(gpio_sts)
  );

  sts_sticky_bank #(.W(BDI_W)) u_bdi_sts (
    .clk_i, .rst_ni,
    .evt_i(bdi_evt_i), .en_i({BDI_W{1'b1}}),
    .clr_i(clr_sel_i == CLR_BDI), .clr_data_i(clr_data_i[BDI_W-1:0]),
    .sts_o(bdi_sts)
  );

  sts_sticky_bank #(.W(IEC_W)) u_iec_sts (
    .clk_i, .rst_ni,
    .evt_i(iec_evt_i), .en_i(iec_en_i),
    .clr_i(clr_sel_i == CLR_IEC), .clr_data_i(clr_data_i[IEC_W-1:0]),
    .sts_o(iec_sts)
  );

  assign bdi_flag = |(bdi_sts & bdi_cfg_i);
  assign iec_flag = |iec_sts;
  assign irq_flag = (|gpio_sts) | bdi_flag | iec_flag;

  always_comb begin
    slot12_d         = '0;
    slot12_d.pins    = gpio_lvl;
    slot12_d.bdi     = bdi_flag;
    slot12_d.iec     = iec_flag;
    slot12_d.irq     = irq_flag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      slot12_q <= '0;
    else if (frame_i) slot12_q <= slot12_d;
  end

  assign slot12_o = slot12_q;

  p_slot12_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(slot12_o));

  p_iec_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && |iec_sts) |=> (slot12_o[1] && slot12_o[0]));

  p_gpio_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && |gpio_sts) |=> slot12_o[0]);

  p_flags_imply_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot12_o[2] || slot12_o[1]) |-> slot12_o[0]);
endmodule

// File: tb/codec_status_slots_tb_top.sv
`timescale 1ns/1ps
module codec_status_slots_tb_top;
  localparam int ADDR_W = 7, BDI_W = 8, IEC_W = 4, CLR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              frame = 0, rd_v = 0;
  logic [ADDR_W-1:0] rd_a = '0;
  logic [15:0]       rd_d = '0;
  logic [4:0]        pin = '0, dir = '0, ctl = '0, wake = '0;
  logic [BDI_W-1:0]  bdi_evt = '0, bdi_cfg = '0;
  logic [IEC_W-1:0]  iec_evt = '0, iec_en = '0;
  logic [1:0]        clr_sel = 2'd3;
  logic [CLR_W-1:0]  clr_data = '1;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_v;
  logic [19:0]       s2, s12;

  codec_status_slots #(.ADDR_W(ADDR_W), .BDI_W(BDI_W), .IEC_W(IEC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame),
    .rd_valid_i(rd_v), .rd_addr_i(rd_a), .rd_data_i(rd_d),
    .gpio_pin_i(pin), .gpio_dir_i(dir), .gpio_ctl_i(ctl), .gpio_wake_i(wake),
    .bdi_evt_i(bdi_evt), .bdi_cfg_i(bdi_cfg), .iec_evt_i(iec_evt), .iec_en_i(iec_en),
    .clr_sel_i(clr_sel), .clr_data_i(clr_data),
    .slot1_addr_o(s1_addr), .slot1_valid_o(s1_v), .slot2_o(s2), .slot12_o(s12)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [4:0]        m_gsts = '0, m_gprev = '0, m_echo = '0;
  logic [BDI_W-1:0]  m_bsts = '0, m_bprev = '0;
  logic [IEC_W-1:0]  m_ists = '0, m_iprev = '0;
  logic              m_pv = 0, m_v = 0;
  logic [ADDR_W-1:0] m_pa = '0, m_a = '0;
  logic [15:0]       m_pd = '0;
  logic [19:0]       m_s2 = '0, m_s12 = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] exp_slot12();
    logic [4:0] lvl = (dir & m_echo) | (~dir & pin);
    logic b = |(m_bsts & bdi_cfg);
    logic i = |m_ists;
    return {11'b0, lvl, 1'b0, b, i, (|m_gsts) | b | i};
  endfunction

  task automatic compare_all();
    chk("R2 slot1 valid", 32'(s1_v), 32'(m_v));
    chk("R2 slot1 addr", 32'(s1_addr), 32'(m_a));
    chk("R3 slot2", 32'(s2), 32'(m_s2));
    chk("R4/R13 slot12", 32'(s12), 32'(m_s12));
  endtask

  task automatic cyc();
    logic [4:0] gclr = (clr_sel == 2'd0) ? ~clr_data[4:0] : '0;
    logic [BDI_W-1:0] bclr = (clr_sel == 2'd1) ? ~clr_data[BDI_W-1:0] : '0;
    logic [IEC_W-1:0] iclr = (clr_sel == 2'd2) ? ~clr_data[IEC_W-1:0] : '0;
    logic [4:0] gs = (m_gsts & ~gclr) | (pin & ~m_gprev & wake & ~dir);
    logic [BDI_W-1:0] bs = (m_bsts & ~bclr) | (bdi_evt & ~m_bprev);
    logic [IEC_W-1:0] is = (m_ists & ~iclr) | (iec_evt & ~m_iprev & iec_en);
    logic [19:0] s12n = frame ? exp_slot12() : m_s12;
    logic [4:0] en = frame ? ctl : m_echo;
    logic v = m_v, pv = m_pv;
    logic [ADDR_W-1:0] a = m_a, pa = m_pa;
    logic [15:0] pd = m_pd;
    logic [19:0] s2n = m_s2;
    if (frame) begin
      v = m_pv; a = m_pv ? m_pa : '0; s2n = m_pv ? {m_pd, 4'b0} : '0; pv = rd_v;
    end else if (rd_v) pv = 1'b1;
    if (rd_v) begin pa = rd_a; pd = rd_d; end
    @(posedge clk);
    m_gsts = gs; m_bsts = bs; m_ists = is;
    m_gprev = pin; m_bprev = bdi_evt; m_iprev = iec_evt;
    m_s12 = s12n; m_echo = en; m_v = v; m_a = a; m_s2 = s2n;
    m_pv = pv; m_pa = pa; m_pd = pd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobe();
    frame = 1; cyc(); frame = 0; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_1234;
    int gap;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 slot1 valid", 32'(s1_v), 0);
    chk("R1 slot1 addr", 32'(s1_addr), 0);
    chk("R1 slot2", 32'(s2), 0);
    chk("R1 slot12", 32'(s12), 0);
    rst_n = 1;
    cyc(); cyc();

    // R2/R3 read returns one frame late
    strobe();
    rd_v = 1; rd_a = 7'h2A; rd_d = 16'hBEEF; cyc(); rd_v = 0; cyc();
    chk("R2 no early return", 32'(s1_v), 0);
    strobe();
    chk("R2 valid after strobe", 32'(s1_v), 1);
    chk("R2 addr", 32'(s1_addr), 32'h2A);
    chk("R3 slot2 layout", 32'(s2), 32'hBEEF0);
    strobe();
    chk("R2 empty frame", 32'(s1_v), 0);
    chk("R2 empty slot2", 32'(s2), 0);

    // R5/R6/R9 pin reporting and output echo lag
    dir = 5'b00001; ctl = 5'b00001; pin = 5'b00010; cyc();
    strobe();
    chk("R6 output lag frame A", 32'(s12[4]), 0);
    chk("R5 input pin live", 32'(s12[5]), 1);
    chk("R9 no wake no irq", 32'(s12[0]), 0);
    strobe();
    chk("R6 output echo frame B", 32'(s12[4]), 1);
    pin = 5'b0; dir = 5'b0; ctl = 5'b0; cyc();

    // R12 set beats clear, then R11 clear
    iec_en = 4'h1; iec_evt = 4'h1; clr_sel = 2'd2; clr_data = '0; cyc();
    clr_sel = 2'd3; clr_data = '1; cyc();
    strobe();
    chk("R12 iec kept", 32'(s12[1]), 1);
    chk("R10 irq from iec", 32'(s12[0]), 1);
    clr_sel = 2'd2; clr_data = '0; cyc(); clr_sel = 2'd3; clr_data = '1;
    strobe();
    chk("R11 iec cleared", 32'(s12[1]), 0);
    chk("R11 irq cleared", 32'(s12[0]), 0);
    iec_evt = 0; cyc();
    // R8 disabled source ignored
    iec_en = 4'h0; iec_evt = 4'h2; cyc(); strobe();
    chk("R8 disabled iec", 32'(s12[1]), 0);
    iec_evt = 0;

    // R7 BIOS-event masking
    bdi_cfg = '0; bdi_evt = 8'h01; cyc(); strobe();
    chk("R7 masked bdi", 32'(s12[2]), 0);
    chk("R10 masked bdi no irq", 32'(s12[0]), 0);
    bdi_cfg = 8'h01; cyc(); strobe();
    chk("R7 bdi unmasked", 32'(s12[2]), 1);
    chk("R10 bdi irq", 32'(s12[0]), 1);
    clr_sel = 2'd1; clr_data = 8'hFE; cyc(); clr_sel = 2'd3; clr_data = '1;
    strobe();
    chk("R11 bdi cleared", 32'(s12[2]), 0);
    bdi_evt = 0; bdi_cfg = '0;

    // R9 wake on input pin
    wake = 5'b00100; pin = 5'b00100; cyc(); strobe();
    chk("R9 wake irq", 32'(s12[0]), 1);
    clr_sel = 2'd0; clr_data = 8'hFB; cyc(); clr_sel = 2'd3; clr_data = '1;
    strobe();
    chk("R11 gpio cleared", 32'(s12[0]), 0);

    // random phase; R13 via per-cycle compare
    gap = 0;
    for (int k = 0; k < 5000; k++) begin
      frame = (gap == 0);
      gap = frame ? 5 + ($urandom % 8) : gap - 1;
      rd_v = ($urandom % 5) == 0; rd_a = ADDR_W'($urandom); rd_d = 16'($urandom);
      if (($urandom % 6) == 0) pin = pin ^ 5'(1 << ($urandom % 5));
      if (($urandom % 6) == 0) bdi_evt = bdi_evt ^ BDI_W'(1 << ($urandom % BDI_W));
      if (($urandom % 6) == 0) iec_evt = iec_evt ^ IEC_W'(1 << ($urandom % IEC_W));
      if (($urandom % 50) == 0) ctl = 5'($urandom);
      if (($urandom % 150) == 0) dir = 5'($urandom);
      if (($urandom % 150) == 0) wake = 5'($urandom);
      if (($urandom % 150) == 0) bdi_cfg = BDI_W'($urandom);
      if (($urandom % 150) == 0) iec_en = IEC_W'($urandom);
      clr_sel = (($urandom % 8) == 0) ? 2'($urandom) : 2'd3;
      clr_data = CLR_W'($urandom) | CLR_W'($urandom);
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule